// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one programmable logic cell meant to be repeated across a reconfigurable fabric. A 4-input lookup table produces any Boolean function of its inputs. The function is set by a truth table held in configuration storage. The table result goes to two places. One is straight to the output. The other is a single-bit state register, which lets the cell build sequential logic. A configuration bit chooses which of the two drives the cell output. A second configuration bit sets the value the state register takes on start-up and on reset.

The cell's configuration is an 18-bit frame, loaded serially. While the load-enable input is high, the frame shifts in one bit per clock, the first bit sent landing in the top position. The bit leaving the top of the frame appears on a chain output, so that many cells can be loaded over a single wire. While a load is under way, the cell output is forced low, so a half-written function never reaches the logic downstream.

The reset input is asynchronous and active low, and its release is synchronized. Reset only puts the state register back to its programmed start value. The loaded frame is left untouched.

Top module: `lutcell_top`

## Requirements
- R1: While `cfg_mode` is 1, `cell_out` is 0 whatever the frame, inputs or reset.
- R2: Each clock edge with `cfg_mode` high shifts `cfg_in` into frame bit 0, and every other bit moves up one place. After 18 such edges the first bit sent sits in bit 17. The frame layout is: bits 15..0 are the truth table, bit 16 is the output select, and bit 17 is the register start value.
- R3: `cfg_out` always shows frame bit 17. During a reload, after k shifts it shows bit 17-k of the old frame.
- R4: With output select 0 and `cfg_mode` low, `cell_out` equals truth-table bit number `lut_in`, read as an unsigned index, in the same cycle.
- R5: With output select 1 and the cell running, `cell_out` equals the truth-table bit addressed by `lut_in` at the previous clock edge.
- R6: In the first cycle after `cfg_mode` falls, a cell with output select 1 shows the start value it has just loaded.
- R7: With `rst_n` low, the state register loads the start value on every edge. After `rst_n` rises, it keeps loading it for two more edges, then follows the table. The stored frame is left unchanged.
- R8: Changes on `cfg_in` while `cfg_mode` is low leave the frame unchanged. Both the table output and `cfg_out` stay as loaded.
- R9: Loading table value 16'h6996 with output select 0 makes `cell_out` the odd parity of `lut_in`. Its low eight entries read 0,1,1,0,1,0,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_mode | input | 1 | High while the configuration frame is being shifted in |
| cfg_in | input | 1 | Serial configuration data, top bit of the frame first |
| cfg_out | output | 1 | Frame bit 17, for daisy-chaining cells |
| lut_in | input | 4 | Logic inputs that index the truth table |
| cell_out | output | 1 | Cell result, combinational or registered |

## Verification
The bench builds the cell with its default parameters: four table inputs, giving a 16-entry table and an 18-bit frame, and a two-stage reset synchronizer. With these values every table address can be swept exhaustively after each load. The frame is short enough that one reload moves every old bit past `cfg_out`, so the chain output can be compared bit by bit. The two-edge reset-release window is also short enough to check edge by edge. Random frames in both output modes are mixed with directed cases: the parity table, a load done while reset is held, and a reset released with a table of all ones against a start value of 0.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_sel_e;

  function automatic int table_bits(input int n_inputs);
    return 1 << n_inputs;
  endfunction

endpackage

// File: rtl/lutcell_rst_sync.sv
module lutcell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lutcell_cfg_chain.sv
module lutcell_cfg_chain #(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode,
  input  logic               cfg_in,
  output logic [FRAME_W-1:0] frame,
  output logic               init_next,
  output logic               cfg_out
);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;
  logic               shift_en;

  assign shift_en = cfg_mode;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) frame_d = {frame_q[FRAME_W-2:0], cfg_in};
  end

  always_ff @(posedge clk) begin
    if (shift_en) frame_q <= frame_d;
  end

  assign frame     = frame_q;
  assign init_next = frame_d[FRAME_W-1];
  assign cfg_out   = frame_q[FRAME_W-1];

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> frame_q[0] == $past(cfg_in)); // R2

  AST_CHAIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> cfg_out == $past(frame_q[FRAME_W-2])); // R3

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(frame_q)); // R8

endmodule

// File: rtl/lutcell_lut_mux.sv
module lutcell_lut_mux #(
  parameter int N_IN = 4,
  localparam int ENTRIES = 1 << N_IN
) (
  input  logic [ENTRIES-1:0] truth,
  input  logic [N_IN-1:0]    sel,
  output logic               y
);

  logic [N_IN:0][ENTRIES-1:0] stage;

  assign stage[0] = truth;

  for (genvar lv = 0; lv < N_IN; lv++) begin : g_level
    localparam int LIVE = ENTRIES >> (lv + 1);
    for (genvar j = 0; j < ENTRIES; j++) begin : g_node
      if (j < LIVE) begin : g_pick
        assign stage[lv+1][j] = sel[lv] ? stage[lv][2*j+1] : stage[lv][2*j];
      end else begin : g_pad
        assign stage[lv+1][j] = 1'b0;
      end
    end
  end

  assign y = stage[N_IN][0];

endmodule

// File: rtl/lutcell_state_ff.sv
module lutcell_state_ff (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic cfg_mode,
  input  logic init_val,
  input  logic d,
  output logic q
);

  logic hold_init;
  logic q_d;
  logic q_r;

  always_comb begin
    hold_init = !rst_sync_n || cfg_mode;
    q_d       = hold_init ? init_val : d;
  end

  always_ff @(posedge clk) begin
    q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
  import lutcell_pkg::*;
#(
  parameter int N_IN        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_mode,
  input  logic            cfg_in,
  output logic            cfg_out,
  input  logic [N_IN-1:0] lut_in,
  output logic            cell_out
);

  localparam int ENTRIES = 1 << N_IN;
  localparam int FRAME_W = ENTRIES + 2;
  localparam int SEL_POS  = ENTRIES;
  localparam int INIT_POS = ENTRIES + 1;

  logic               rst_sync_n;
  logic [FRAME_W-1:0] frame;
  logic               init_next;
  logic               lut_y;
  logic               ff_q;
  out_sel_e           out_sel;
  logic               ff_init;

  lutcell_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lutcell_cfg_chain #(.FRAME_W(FRAME_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_in    (cfg_in),
    .frame     (frame),
    .init_next (init_next),
    .cfg_out   (cfg_out)
  );

  lutcell_lut_mux #(.N_IN(N_IN)) u_lut (
    .truth (frame[ENTRIES-1:0]),
    .sel   (lut_in),
    .y     (lut_y)
  );

  lutcell_state_ff u_ff (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .cfg_mode   (cfg_mode),
    .init_val   (init_next),
    .d          (lut_y),
    .q          (ff_q)
  );

  assign out_sel = out_sel_e'(frame[SEL_POS]);
  assign ff_init = frame[INIT_POS];

  always_comb begin
    if (cfg_mode)               cell_out = 1'b0;
    else if (out_sel == OUT_REG) cell_out = ff_q;
    else                        cell_out = lut_y;
  end

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> !cell_out); // R1

  AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && out_sel == OUT_COMB) |-> cell_out == frame[lut_in]); // R4

  AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_sync_n) && !$past(cfg_mode) && !cfg_mode && out_sel == OUT_REG)
      |-> cell_out == $past(frame[lut_in])); // R5

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg_mode) && out_sel == OUT_REG) |-> cell_out == ff_init); // R6

  AST_RESET_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_sync_n) && !cfg_mode && out_sel == OUT_REG) |-> cell_out == ff_init); // R7

endmodule

// File: tb/sim_lutcell_top.sv
module sim_lutcell_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_mode;
  logic       cfg_in;
  logic       cfg_out;
  logic [3:0] lut_in;
  logic       cell_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [17:0] cur_frame;
  logic        exp_q;
  bit          in_rst;
  int          hold_cnt;
  bit          first_after_load;

  always #5 clk = ~clk;

  lutcell_top u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .cfg_in   (cfg_in),
    .cfg_out  (cfg_out),
    .lut_in   (lut_in),
    .cell_out (cell_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic table_at(input logic [17:0] f, input logic [3:0] idx);
    return f[idx];
  endfunction

  task automatic load_frame(input logic [17:0] f, input bit chk_chain);
    for (int i = 17; i >= 0; i--) begin
      @(negedge clk);
      cfg_mode = 1'b1;
      cfg_in   = f[i];
      lut_in   = 4'($urandom);
      #1;
      check("R1", cell_out, 1'b0);
      if (chk_chain) check("R3", cfg_out, cur_frame[i]);
    end
    cur_frame        = f;
    exp_q            = f[17];
    first_after_load = 1;
  endtask

  task automatic step(input logic [3:0] v);
    logic exp;
    string tag;
    @(negedge clk);
    cfg_mode = 1'b0;
    cfg_in   = 1'($urandom);
    lut_in   = v;
    #1;
    if (cur_frame[16]) begin
      exp = exp_q;
      tag = first_after_load ? "R6" : (in_rst || hold_cnt > 0) ? "R7" : "R5";
    end else begin
      exp = table_at(cur_frame, v);
      tag = "R4";
    end
    check(tag, cell_out, exp);
    first_after_load = 0;
    if (in_rst) exp_q = cur_frame[17];
    else if (hold_cnt > 0) begin
      exp_q = cur_frame[17];
      hold_cnt--;
    end else exp_q = table_at(cur_frame, v);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    if (cur_frame[16]) check("R7", cell_out, cur_frame[17]);
    in_rst   = 0;
    exp_q    = cur_frame[17];
    hold_cnt = 1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cfg_mode = 1'b1; cfg_in = 1'b0; lut_in = '0;
    in_rst = 1; hold_cnt = 0; first_after_load = 0; cur_frame = '0;
    repeat (2) @(negedge clk);
    #1;
    check("R1", cell_out, 1'b0);

    // load under reset: registered mode, start 1, table all zeros
    load_frame({1'b1, 1'b1, 16'h0000}, 0);
    for (int k = 0; k < 4; k++) step(4'($urandom)); // R7 holds start value
    release_reset();
    for (int k = 0; k < 4; k++) step(4'($urandom)); // R5 then zeros

    // R7: table all ones, start 0, reset asserted and released
    load_frame({1'b0, 1'b1, 16'hFFFF}, 1);
    for (int k = 0; k < 3; k++) step(4'($urandom));
    @(negedge clk); rst_n = 1'b0; in_rst = 1; exp_q = cur_frame[17];
    for (int k = 0; k < 3; k++) step(4'($urandom));
    release_reset();
    for (int k = 0; k < 4; k++) step(4'($urandom));

    // R9: odd parity table, exhaustive sweep
    load_frame({1'b0, 1'b0, 16'h6996}, 1);
    for (int a = 0; a < 16; a++) begin
      step(4'(a));
      check("R9", cell_out, ^4'(a));
    end

    // R8: cfg_in toggled while idle (step randomizes it), table still intact
    for (int k = 0; k < 20; k++) step(4'($urandom));
    for (int a = 0; a < 16; a++) step(4'(a));
    check("R8", cfg_out, 1'b0);

    // R2: frame layout and shift order seen through the sweep of a known frame
    load_frame({1'b1, 1'b0, 16'hA5C3}, 1);
    for (int a = 0; a < 16; a++) begin
      step(4'(a));
      check("R2", cell_out, 1'(16'hA5C3 >> a));
    end
    check("R2", cfg_out, 1'b1);

    // random frames in both modes
    for (int n = 0; n < 12; n++) begin
      load_frame(18'($urandom), 1);
      for (int k = 0; k < 40; k++) step(4'($urandom));
      check("R8", cfg_out, cur_frame[17]);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule